// File: doc/BRIEF.md
# Output Fault Protection Latch

This block sits between the software power-enable bits of a codec's output stages and the actual power-enable lines of those stages. It watches digital fault flags coming from three headphone drivers (left, right and common) and two speaker drivers (left and right). A headphone short takes down only the headphone driver that reported it. An over-temperature event on a speaker takes down every analog output until software releases it.

Each fault flag passes through a synchronizer and a qualifier before it can latch. A flag must therefore be seen high on consecutive clocks, and single-cycle glitches are dropped. Software sees one status word and has two ways to act on it. It clears short faults with per-driver clear strobes. It frees thermal faults with per-side release strobes. Every gated enable is the software enable with the block's own fault and any thermal fault masked out.

Top module: `out_fault_guard`

## Requirements
- R1: A short flag on an enabled headphone driver, held high for two or more clocks, drives that driver's gated enable low at the fourth rising clock edge after the flag is first sampled, and not before. The other headphone and speaker enables do not change.
- R2: The status word holds left, right and common headphone shorts in bits 0, 1 and 2. It holds left and right speaker thermal faults in bits 3 and 4. Several short bits can be set at the same time.
- R3: A short flag on a headphone driver whose software enable is low is ignored, and its status bit stays 0. If the enable is raised while the qualified flag is still high, the fault latches on the next clock edge.
- R4: A fault flag that is high for only one clock never latches. This holds for shorts and for thermal flags.
- R5: A latched short stays latched after its flag goes low. It is cleared on the next edge by dropping the driver's software enable, or by its clear strobe (bit i of the clear input) once the synchronized flag is low. A clear strobe while the flag is still high has no effect.
- R6: A qualified over-temperature flag on an enabled speaker forces all three headphone enables and both speaker enables low.
- R7: Thermal status is kept per side. A thermal flag on a speaker whose software enable is low is ignored.
- R8: A thermal fault stays latched after its flag falls, until the release strobe of the same side is asserted. A release of the other side does not clear it. If the flag is still high at release, the fault latches again one edge later.
- R9: Each gated enable is high only when its software enable is high, its own short is clear and no thermal fault is latched.
- R10: The synchronous active-low reset clears every latched fault and every status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_en_sw | input | 3 | Software headphone enables (0 left, 1 right, 2 common) |
| spk_en_sw | input | 2 | Software speaker enables (0 left, 1 right) |
| short_in | input | 3 | Asynchronous headphone short flags, same bit order |
| hot_in | input | 2 | Asynchronous speaker over-temperature flags |
| short_clr | input | 3 | Per-driver short clear strobes |
| therm_rel | input | 2 | Per-side thermal release strobes |
| hp_pwr | output | 3 | Gated headphone power enables |
| spk_pwr | output | 2 | Gated speaker power enables |
| status | output | 5 | Fault status word: shorts in bits 2:0, thermal in bits 4:3 |

## Verification
A fault flag goes through two synchronizer flops and one qualifier count, and then latches. The gated enables and status bits therefore change at the fourth rising edge after the flag is first sampled. Strobes, enable changes and releases act at the first edge. The bench drives inputs on the falling edge and samples on later falling edges. It checks one sample before each due edge to show the result is not early, and one sample after it. Short pulses are followed by several idle cycles before the status is read, so that a late latch would be caught.

// File: rtl/fg_pkg.sv
package fg_pkg;
    // Number of headphone drivers watched (left, right, common)
    localparam int HP_N  = 3;
    // Number of speaker drivers watched (left, right)
    localparam int SPK_N = 2;
    // Width of the status word: short bits low, thermal bits high
    localparam int STAT_W = HP_N + SPK_N;
endpackage

// File: rtl/fg_flag_sync.sv
// fg_flag_sync: brings one asynchronous fault flag into the clock domain
// and qualifies it. Assumes SYNC_STAGES >= 2 and QUAL_CYCLES >= 1.
// level: synchronized flag; qual: synchronized flag high for QUAL_CYCLES
// consecutive clocks.
module fg_flag_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic qual
);
    localparam int CW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CYCLES - 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          run_cnt;

    // Shift the raw flag through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], raw};
    end

    assign level = chain[SYNC_STAGES-1];

    // Count consecutive high cycles of the synchronized flag, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (!level)            run_cnt <= '0;
        else if (run_cnt != CNT_TOP) run_cnt <= run_cnt + 1'b1;
    end

    assign qual = level && (run_cnt == CNT_TOP);

    AST_QUAL_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (QUAL_CYCLES < 2) || $past(level)); // R4
endmodule

// File: rtl/fg_short_latch.sv
// fg_short_latch: holds one headphone short fault. Sets on a qualified
// flag while the software enable is high. Clears when the enable drops,
// or on a clear strobe while the synchronized flag is low.
module fg_short_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic level,
    input  logic en,
    input  logic clr,
    output logic lat
);
    // Update the short fault bit
    always_ff @(posedge clk) begin
        if (!rst_n)            lat <= 1'b0;
        else if (!en)          lat <= 1'b0;
        else if (clr && !level) lat <= 1'b0;
        else if (qual)         lat <= 1'b1;
    end

    AST_SHORT_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !lat); // R3
    AST_SHORT_SET_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat) |-> $past(qual) && $past(en)); // R4
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lat && en && !(clr && !level) |=> lat); // R5
endmodule

// File: rtl/fg_therm_latch.sv
// fg_therm_latch: holds one speaker thermal fault. Sets on a qualified
// flag while the software enable is high. Only the release strobe of
// its own side clears it.
module fg_therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic en,
    input  logic rel,
    output logic lat
);
    // Update the thermal fault bit
    always_ff @(posedge clk) begin
        if (!rst_n)         lat <= 1'b0;
        else if (rel)       lat <= 1'b0;
        else if (qual && en) lat <= 1'b1;
    end

    AST_THERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !lat); // R8
    AST_THERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lat && !rel |=> lat); // R8
endmodule

// File: rtl/out_fault_guard.sv
// out_fault_guard: fault protection for headphone and speaker stages.
// Headphone shorts gate their own driver. Any speaker thermal fault gates
// every output. Fault inputs are asynchronous; strobes and enables are
// synchronous to clk.
module out_fault_guard
    import fg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HP_N-1:0]   hp_en_sw,
    input  logic [SPK_N-1:0]  spk_en_sw,
    input  logic [HP_N-1:0]   short_in,
    input  logic [SPK_N-1:0]  hot_in,
    input  logic [HP_N-1:0]   short_clr,
    input  logic [SPK_N-1:0]  therm_rel,
    output logic [HP_N-1:0]   hp_pwr,
    output logic [SPK_N-1:0]  spk_pwr,
    output logic [STAT_W-1:0] status
);
    logic [HP_N-1:0]  short_lvl, short_qual, short_lat;
    logic [SPK_N-1:0] hot_lvl, hot_qual, therm_lat;
    logic             any_therm;

    // One synchronizer and short latch per headphone driver
    for (genvar i = 0; i < HP_N; i++) begin : g_hp
        fg_flag_sync #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) u_sync (
            .clk(clk), .rst_n(rst_n), .raw(short_in[i]),
            .level(short_lvl[i]), .qual(short_qual[i]));
        fg_short_latch u_lat (
            .clk(clk), .rst_n(rst_n), .qual(short_qual[i]), .level(short_lvl[i]),
            .en(hp_en_sw[i]), .clr(short_clr[i]), .lat(short_lat[i]));

        AST_SHORT_CUTS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
            short_qual[i] && hp_en_sw[i] |=> !hp_pwr[i]); // R1
    end

    // One synchronizer and thermal latch per speaker side
    for (genvar j = 0; j < SPK_N; j++) begin : g_spk
        fg_flag_sync #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) u_sync (
            .clk(clk), .rst_n(rst_n), .raw(hot_in[j]),
            .level(hot_lvl[j]), .qual(hot_qual[j]));
        fg_therm_latch u_lat (
            .clk(clk), .rst_n(rst_n), .qual(hot_qual[j]), .en(spk_en_sw[j]),
            .rel(therm_rel[j]), .lat(therm_lat[j]));

        AST_THERM_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            hot_qual[j] && spk_en_sw[j] && !therm_rel[j] |=>
                (hp_pwr == '0) && (spk_pwr == '0)); // R6
    end

    // Gate software enables with own and global faults
    always_comb begin
        any_therm = |therm_lat;
        hp_pwr    = hp_en_sw & ~short_lat & {HP_N{~any_therm}};
        spk_pwr   = spk_en_sw & {SPK_N{~any_therm}};
        status    = {therm_lat, short_lat};
    end

    // Unused-lint guard: hot_lvl is only for observation of the sync chain
    logic hot_lvl_seen;
    assign hot_lvl_seen = |hot_lvl;

    AST_NO_SW_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        ((hp_pwr & ~hp_en_sw) == '0) && ((spk_pwr & ~spk_en_sw) == '0)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (status == '0)); // R10
endmodule

// File: tb/out_fault_guard_bench.sv
module out_fault_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hp_en_sw, short_in, short_clr, hp_pwr;
    logic [1:0] spk_en_sw, hot_in, therm_rel, spk_pwr;
    logic [4:0] status;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    out_fault_guard u_out_fault_guard (
        .clk(clk), .rst_n(rst_n), .hp_en_sw(hp_en_sw), .spk_en_sw(spk_en_sw),
        .short_in(short_in), .hot_in(hot_in), .short_clr(short_clr),
        .therm_rel(therm_rel), .hp_pwr(hp_pwr), .spk_pwr(spk_pwr), .status(status));

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Compare the whole output image {hp_pwr, spk_pwr, status}
    task automatic chk_all(input string req, input logic [2:0] hp, input logic [1:0] sp,
                           input logic [4:0] st);
        chk(req, {hp_pwr, spk_pwr, status}, {hp, sp, st});
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        short_clr = m; cyc(1); short_clr = '0;
    endtask

    task automatic pulse_rel(input logic [1:0] m);
        therm_rel = m; cyc(1); therm_rel = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; hp_en_sw = 3'b111; spk_en_sw = 2'b11;
        short_in = '0; hot_in = '0; short_clr = '0; therm_rel = '0;
        cyc(3); rst_n = 1'b1; cyc(1);
        chk_all("R10 reset state", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_short_basic;
        short_in[1] = 1'b1; cyc(3);
        chk_all("R1 right short not early", 3'b111, 2'b11, 5'b00000);
        cyc(1);
        chk_all("R1 R2 right short cuts only right", 3'b101, 2'b11, 5'b00010);
        short_in[2] = 1'b1; cyc(4);
        chk_all("R2 common short adds bit 2", 3'b001, 2'b11, 5'b00110);
        short_in = '0; cyc(4); pulse_clr(3'b110);
        chk_all("R5 clear strobes with flags low", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_short_hold;
        short_in[0] = 1'b1; cyc(6);
        chk_all("R2 left short bit 0", 3'b110, 2'b11, 5'b00001);
        pulse_clr(3'b001);
        chk_all("R5 clear while flag high ignored", 3'b110, 2'b11, 5'b00001);
        short_in[0] = 1'b0; cyc(6);
        chk_all("R5 short held after flag low", 3'b110, 2'b11, 5'b00001);
        hp_en_sw[0] = 1'b0; cyc(1);
        chk_all("R5 disable clears short", 3'b110, 2'b11, 5'b00000);
        hp_en_sw[0] = 1'b1; cyc(1);
        chk_all("R9 re-enable restores power", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_pulse;
        short_in[0] = 1'b1; cyc(1); short_in[0] = 1'b0; cyc(6);
        chk_all("R4 one-cycle short dropped", 3'b111, 2'b11, 5'b00000);
        hot_in[1] = 1'b1; cyc(1); hot_in[1] = 1'b0; cyc(6);
        chk_all("R4 one-cycle thermal dropped", 3'b111, 2'b11, 5'b00000);
        short_in[0] = 1'b1; cyc(2); short_in[0] = 1'b0; cyc(1);
        chk_all("R4 two-cycle short not early", 3'b111, 2'b11, 5'b00000);
        cyc(1);
        chk_all("R4 two-cycle short latched", 3'b110, 2'b11, 5'b00001);
        cyc(3); pulse_clr(3'b001);
        chk_all("R5 clear after two-cycle short", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_disabled;
        hp_en_sw[2] = 1'b0; short_in[2] = 1'b1; cyc(6);
        chk_all("R3 disabled short ignored", 3'b011, 2'b11, 5'b00000);
        hp_en_sw[2] = 1'b1; cyc(1);
        chk_all("R3 enable with flag high latches", 3'b011, 2'b11, 5'b00100);
        short_in[2] = 1'b0; cyc(4); pulse_clr(3'b100);
        spk_en_sw[0] = 1'b0; hot_in[0] = 1'b1; cyc(6);
        chk_all("R7 disabled speaker thermal ignored", 3'b111, 2'b10, 5'b00000);
        hot_in[0] = 1'b0; cyc(4); spk_en_sw[0] = 1'b1; cyc(1);
        chk_all("R7 no late thermal latch", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_therm;
        hot_in[0] = 1'b1; cyc(3);
        chk_all("R6 thermal not early", 3'b111, 2'b11, 5'b00000);
        cyc(1);
        chk_all("R6 R7 left thermal kills all", 3'b000, 2'b00, 5'b01000);
        hot_in[0] = 1'b0; cyc(6);
        chk_all("R8 thermal held after flag low", 3'b000, 2'b00, 5'b01000);
        pulse_rel(2'b10);
        chk_all("R8 other-side release ignored", 3'b000, 2'b00, 5'b01000);
        pulse_rel(2'b01);
        chk_all("R8 own release restores", 3'b111, 2'b11, 5'b00000);
        hot_in[1] = 1'b1; cyc(4);
        chk_all("R7 right thermal bit 4", 3'b000, 2'b00, 5'b10000);
        pulse_rel(2'b10);
        chk_all("R8 release with flag high clears", 3'b111, 2'b11, 5'b00000);
        cyc(1);
        chk_all("R8 relatch while flag high", 3'b000, 2'b00, 5'b10000);
        hot_in[1] = 1'b0; cyc(4); pulse_rel(2'b10);
        chk_all("R8 final release", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_gate;
        hp_en_sw = 3'b010; spk_en_sw = 2'b01; cyc(1);
        chk_all("R9 partial software enables", 3'b010, 2'b01, 5'b00000);
        short_in[1] = 1'b1; cyc(4);
        chk_all("R9 own short masks enable", 3'b000, 2'b01, 5'b00010);
        short_in[1] = 1'b0; cyc(4); pulse_clr(3'b010);
        hp_en_sw = 3'b111; spk_en_sw = 2'b11; cyc(1);
        chk_all("R9 full enables", 3'b111, 2'b11, 5'b00000);
    endtask

    task automatic t_reset_mid;
        short_in[0] = 1'b1; hot_in[1] = 1'b1; cyc(5);
        chk_all("R10 faults latched before reset", 3'b000, 2'b00, 5'b10001);
        short_in = '0; hot_in = '0;
        rst_n = 1'b0; cyc(1);
        chk_all("R10 reset clears latches", 3'b111, 2'b11, 5'b00000);
        rst_n = 1'b1; cyc(4);
        chk_all("R10 stays clear after reset", 3'b111, 2'b11, 5'b00000);
    endtask

    initial begin
        t_reset();
        t_short_basic();
        t_short_hold();
        t_pulse();
        t_disabled();
        t_therm();
        t_gate();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule